// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This controller sits beside one processor's private write-back cache and keeps it consistent with the caches of other processors that share a broadcast message fabric. The cache is direct-mapped. It holds four lines of eight bytes each. Every line has a valid flag and a dirty flag, and no other state is used for coherence. Local requests read or overwrite a whole line. A read miss is announced on the fabric. The line is then delivered either by a peer that holds a modified copy or, when the fabric reports that no peer owns it, by the shared lower level. Before a line is modified, the controller announces a write intent, and peers drop their copies. When a peer asks for a line that this controller holds modified, it writes the line back to memory, clears its dirty flag and sends the data straight to the requester.

The fabric delivers one broadcast at a time. It also generates the "no owner" notice that a requester waits for when no cache supplies the line. Every data-carrying channel uses valid/ready. A transfer takes place on a rising edge where both are high. A source keeps its payload steady while valid is high and ready is low, with one exception: the controller withdraws a pending read-request or write-intent broadcast while an incoming message is being offered, so that snoops are never blocked. The CPU response and the memory read response are single-cycle pulses with no back-pressure.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset all lines are invalid, `cpu_req_ready` is high, and neither `bus_out_valid` nor `mem_req_valid` is asserted.
- R2: A local read that hits gives a one-cycle `cpu_rsp_valid` pulse with the stored line and no fabric or memory activity.
- R3: A local read miss broadcasts message type 01 (read request) carrying the line address (byte address with bits [2:0] cleared) and `bus_out_src` equal to the node identifier.
- R4: When a type 00 (no owner) message addressed to this node answers the read request, the controller reads the line address from memory, installs the returned data clean and returns it to the CPU.
- R5: When a type 11 (data reply) message addressed to this node answers the read request, its data is installed clean and returned to the CPU without any memory access.
- R6: A write to an absent line first performs the full read-miss sequence, then broadcasts type 10 (write intent), then holds the written 64-bit value as a dirty line.
- R7: A write to a line that is present and dirty changes the data with no broadcast and no memory access.
- R8: A write to a line that is present but clean broadcasts type 10 for the line address before the new data is stored, and the line becomes dirty.
- R9: A snooped type 10 from a peer invalidates the matching line. A write intent for an address not held (different tag at the same index) leaves the cache unchanged.
- R10: A snooped type 01 from a peer that hits a dirty line causes a memory write of that line, then a type 11 message to the requester's identifier carrying the line, and leaves the line clean.
- R11: A snooped type 01 that hits a clean line, or misses, produces no message and no memory access.
- R12: The line index is byte-address bits [4:3]. A miss that displaces a dirty line writes that line back to memory at its own address before the read request is broadcast.
- R13: While an incoming message is offered in the idle state, `cpu_req_ready` is low and the snoop is served first. Messages whose source is this node's own identifier are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Local request offered |
| cpu_req_ready | output | 1 | Local request accepted this cycle |
| cpu_req_write | input | 1 | 1 = overwrite the line, 0 = read |
| cpu_req_addr | input | 32 | Byte address of the request |
| cpu_req_wdata | input | 64 | Line value for a write |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_data | output | 64 | Line value after the request |
| bus_out_valid | output | 1 | Outgoing message offered |
| bus_out_ready | input | 1 | Fabric takes the outgoing message |
| bus_out_type | output | 2 | 01 read request, 10 write intent, 11 data reply |
| bus_out_addr | output | 32 | Line address |
| bus_out_data | output | 64 | Line data for a data reply |
| bus_out_src | output | 2 | This node's identifier |
| bus_out_dest | output | 2 | Requester identifier for a data reply |
| bus_in_valid | input | 1 | Incoming message offered |
| bus_in_ready | output | 1 | Controller takes the incoming message |
| bus_in_type | input | 2 | 00 no owner, 01 read request, 10 write intent, 11 data reply |
| bus_in_addr | input | 32 | Line address |
| bus_in_data | input | 64 | Line data of a reply |
| bus_in_src | input | 2 | Sender identifier |
| bus_in_dest | input | 2 | Addressee of a reply or no-owner notice |
| mem_req_valid | output | 1 | Lower-level request offered |
| mem_req_ready | input | 1 | Lower level takes the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | 32 | Line address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 64 | Read data |

## Verification
A wrong valid or dirty flag does not stay hidden, because every flag decides the next message the controller sends. A stale valid flag turns a miss that should broadcast into a silent hit at the CPU port within two cycles. A dirty flag that is wrongly kept shows up as a second write-back and reply on the next snooped read, and one that is wrongly dropped shows up as a missing reply. A wrong tag or index shows up as a write-back to the wrong address on the next eviction. The scenarios are chained, so each leaves state that the next one brings out at the ports.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    MSG_NO_OWNER = 2'b00,
    MSG_RD_REQ   = 2'b01,
    MSG_WR_INV   = 2'b10,
    MSG_DATA     = 2'b11
  } msg_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DECIDE, ST_VICT_WB, ST_RD_BCAST, ST_WAIT_REPLY,
    ST_FILL_REQ, ST_FILL_WAIT, ST_WR_BCAST, ST_RESP, ST_SN_WB, ST_SN_REPLY
  } ctl_state_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int NLINES = 4,
  parameter int TAG_W  = 27,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  la_idx,
  output logic              la_valid,
  output logic              la_dirty,
  output logic [TAG_W-1:0]  la_tag,
  output logic [LINE_W-1:0] la_data,
  input  logic [IDX_W-1:0]  sa_idx,
  output logic              sa_valid,
  output logic              sa_dirty,
  output logic [TAG_W-1:0]  sa_tag,
  output logic [LINE_W-1:0] sa_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_valid,
  input  logic              upd_dirty,
  input  logic              upd_fill,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [LINE_W-1:0] upd_data
);
  logic [NLINES-1:0] valid_v;
  logic [NLINES-1:0] dirty_v;
  logic [TAG_W-1:0]  tag_v  [NLINES];
  logic [LINE_W-1:0] data_v [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [LINE_W-1:0] x_q;
    wire sel = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= upd_valid;
        d_q <= upd_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && upd_fill) begin
        t_q <= upd_tag;
        x_q <= upd_data;
      end
    end

    assign valid_v[g] = v_q;
    assign dirty_v[g] = d_q;
    assign tag_v[g]   = t_q;
    assign data_v[g]  = x_q;

    // R6: a modified line is always a valid line
    p_dirty_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      d_q |-> v_q);
  end

  assign la_valid = valid_v[la_idx];
  assign la_dirty = dirty_v[la_idx];
  assign la_tag   = tag_v[la_idx];
  assign la_data  = data_v[la_idx];
  assign sa_valid = valid_v[sa_idx];
  assign sa_dirty = dirty_v[sa_idx];
  assign sa_tag   = tag_v[sa_idx];
  assign sa_data  = data_v[sa_idx];
endmodule

// File: rtl/coh_snoop_decode.sv
module coh_snoop_decode #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 2,
  parameter int NODE_ID = 1,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [1:0]        msg_kind,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [ID_W-1:0]   msg_src,
  input  logic [ID_W-1:0]   msg_dest,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              do_inv,
  output logic              do_supply,
  output logic              mine_data,
  output logic              mine_none
);
  import coh_pkg::*;
  logic from_peer, to_me, holds;

  always_comb begin
    from_peer = (msg_src != ID_W'(NODE_ID));
    to_me     = (msg_dest == ID_W'(NODE_ID));
    holds     = line_valid && (line_tag == msg_addr[ADDR_W-1:OFF_W+IDX_W]);
    do_inv    = from_peer && holds && (msg_kind == MSG_WR_INV);
    do_supply = from_peer && holds && line_dirty && (msg_kind == MSG_RD_REQ);
    mine_data = to_me && (msg_kind == MSG_DATA);
    mine_none = to_me && (msg_kind == MSG_NO_OWNER);
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int NODE_ID = 1,
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 64,
  parameter int NLINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [LINE_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [LINE_W-1:0] cpu_rsp_data,
  output logic              bus_out_valid,
  input  logic              bus_out_ready,
  output logic [1:0]        bus_out_type,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [LINE_W-1:0] bus_out_data,
  output logic [ID_W-1:0]   bus_out_src,
  output logic [ID_W-1:0]   bus_out_dest,
  input  logic              bus_in_valid,
  output logic              bus_in_ready,
  input  logic [1:0]        bus_in_type,
  input  logic [ADDR_W-1:0] bus_in_addr,
  input  logic [LINE_W-1:0] bus_in_data,
  input  logic [ID_W-1:0]   bus_in_src,
  input  logic [ID_W-1:0]   bus_in_dest,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import coh_pkg::*;

  localparam int LINE_BYTES = LINE_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NLINES);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;

  ctl_state_e st_q, st_d, ret_q, ret_d;
  logic              rq_wr_q, rq_wr_d;
  logic [ADDR_W-1:0] rq_addr_q, rq_addr_d;
  logic [LINE_W-1:0] rq_data_q, rq_data_d;
  logic [ADDR_W-1:0] sn_addr_q, sn_addr_d;
  logic [ID_W-1:0]   sn_src_q, sn_src_d;

  logic [IDX_W-1:0]  rq_idx, sa_idx;
  logic [TAG_W-1:0]  rq_tag;
  logic              la_valid, la_dirty, sa_valid, sa_dirty;
  logic [TAG_W-1:0]  la_tag, sa_tag;
  logic [LINE_W-1:0] la_data, sa_data;
  logic              upd_en, upd_valid, upd_dirty, upd_fill;
  logic [IDX_W-1:0]  upd_idx;
  logic [TAG_W-1:0]  upd_tag;
  logic [LINE_W-1:0] upd_data;
  logic              do_inv, do_supply, mine_data, mine_none;
  logic              snoop_open, in_fire, in_snoop_phase, hit;

  assign rq_idx = rq_addr_q[OFF_W +: IDX_W];
  assign rq_tag = rq_addr_q[ADDR_W-1:OFF_W+IDX_W];
  assign in_snoop_phase = (st_q == ST_SN_WB) || (st_q == ST_SN_REPLY);
  assign sa_idx = in_snoop_phase ? sn_addr_q[OFF_W +: IDX_W] : bus_in_addr[OFF_W +: IDX_W];
  assign hit    = la_valid && (la_tag == rq_tag);

  coh_line_store #(.NLINES(NLINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .la_idx(rq_idx), .la_valid(la_valid), .la_dirty(la_dirty), .la_tag(la_tag), .la_data(la_data),
    .sa_idx(sa_idx), .sa_valid(sa_valid), .sa_dirty(sa_dirty), .sa_tag(sa_tag), .sa_data(sa_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_valid(upd_valid), .upd_dirty(upd_dirty),
    .upd_fill(upd_fill), .upd_tag(upd_tag), .upd_data(upd_data)
  );

  coh_snoop_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ID_W(ID_W),
                     .NODE_ID(NODE_ID)) u_dec (
    .msg_kind(bus_in_type), .msg_addr(bus_in_addr), .msg_src(bus_in_src), .msg_dest(bus_in_dest),
    .line_valid(sa_valid), .line_dirty(sa_dirty), .line_tag(sa_tag),
    .do_inv(do_inv), .do_supply(do_supply), .mine_data(mine_data), .mine_none(mine_none)
  );

  // Snoops are taken wherever the controller is not driving memory or a reply.
  assign snoop_open = (st_q == ST_IDLE) || (st_q == ST_RD_BCAST) ||
                      (st_q == ST_WR_BCAST) || (st_q == ST_WAIT_REPLY);
  assign bus_in_ready  = snoop_open;
  assign in_fire       = bus_in_valid && snoop_open;
  assign cpu_req_ready = (st_q == ST_IDLE) && !bus_in_valid;

  always_comb begin
    bus_out_valid = 1'b0;
    bus_out_type  = MSG_WR_INV;
    bus_out_addr  = rq_addr_q;
    bus_out_data  = '0;
    bus_out_dest  = '0;
    unique case (st_q)
      ST_RD_BCAST: begin bus_out_valid = !bus_in_valid; bus_out_type = MSG_RD_REQ; end
      ST_WR_BCAST: bus_out_valid = !bus_in_valid;
      ST_SN_REPLY: begin
        bus_out_valid = 1'b1;
        bus_out_type  = MSG_DATA;
        bus_out_addr  = sn_addr_q;
        bus_out_data  = sa_data;
        bus_out_dest  = sn_src_q;
      end
      default: ;
    endcase
  end
  assign bus_out_src = ID_W'(NODE_ID);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = rq_addr_q;
    mem_req_wdata = '0;
    unique case (st_q)
      ST_VICT_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {la_tag, rq_idx, {OFF_W{1'b0}}};
        mem_req_wdata = la_data;
      end
      ST_FILL_REQ: mem_req_valid = 1'b1;
      ST_SN_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = sn_addr_q;
        mem_req_wdata = sa_data;
      end
      default: ;
    endcase
  end

  assign cpu_rsp_valid = (st_q == ST_RESP);
  assign cpu_rsp_data  = la_data;

  always_comb begin
    st_d      = st_q;
    ret_d     = ret_q;
    rq_wr_d   = rq_wr_q;
    rq_addr_d = rq_addr_q;
    rq_data_d = rq_data_q;
    sn_addr_d = sn_addr_q;
    sn_src_d  = sn_src_q;
    upd_en    = 1'b0;
    upd_idx   = rq_idx;
    upd_valid = 1'b1;
    upd_dirty = 1'b0;
    upd_fill  = 1'b0;
    upd_tag   = rq_tag;
    upd_data  = rq_data_q;
    if (in_fire) begin
      if (do_inv) begin
        upd_en    = 1'b1;
        upd_idx   = bus_in_addr[OFF_W +: IDX_W];
        upd_valid = 1'b0;
      end else if (do_supply) begin
        sn_addr_d = {bus_in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        sn_src_d  = bus_in_src;
        ret_d     = st_q;
        st_d      = ST_SN_WB;
      end else if (st_q == ST_WAIT_REPLY && mine_data) begin
        upd_en   = 1'b1;
        upd_fill = 1'b1;
        upd_data = bus_in_data;
        st_d     = rq_wr_q ? ST_WR_BCAST : ST_RESP;
      end else if (st_q == ST_WAIT_REPLY && mine_none) begin
        st_d = ST_FILL_REQ;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: if (cpu_req_valid) begin
          rq_wr_d   = cpu_req_write;
          rq_addr_d = {cpu_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          rq_data_d = cpu_req_wdata;
          st_d      = ST_DECIDE;
        end
        ST_DECIDE: begin
          if (hit) begin
            if (!rq_wr_q) st_d = ST_RESP;
            else if (la_dirty) begin
              upd_en    = 1'b1;
              upd_dirty = 1'b1;
              upd_fill  = 1'b1;
              st_d      = ST_RESP;
            end else st_d = ST_WR_BCAST;
          end else if (la_valid && la_dirty) st_d = ST_VICT_WB;
          else st_d = ST_RD_BCAST;
        end
        ST_VICT_WB: if (mem_req_ready) begin
          upd_en    = 1'b1;
          upd_valid = 1'b0;
          st_d      = ST_RD_BCAST;
        end
        ST_RD_BCAST: if (bus_out_ready) st_d = ST_WAIT_REPLY;
        ST_FILL_REQ: if (mem_req_ready) st_d = ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) begin
          upd_en   = 1'b1;
          upd_fill = 1'b1;
          upd_data = mem_rsp_data;
          st_d     = rq_wr_q ? ST_WR_BCAST : ST_RESP;
        end
        ST_WR_BCAST: if (bus_out_ready) begin
          upd_en    = 1'b1;
          upd_dirty = 1'b1;
          upd_fill  = 1'b1;
          st_d      = ST_RESP;
        end
        ST_RESP: st_d = ST_IDLE;
        ST_SN_WB: if (mem_req_ready) begin
          upd_en    = 1'b1;
          upd_idx   = sn_addr_q[OFF_W +: IDX_W];
          upd_dirty = 1'b0;
          st_d      = ST_SN_REPLY;
        end
        ST_SN_REPLY: if (bus_out_ready) st_d = ret_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ret_q     <= ST_IDLE;
      rq_wr_q   <= 1'b0;
      rq_addr_q <= '0;
      rq_data_q <= '0;
      sn_addr_q <= '0;
      sn_src_q  <= '0;
    end else begin
      st_q      <= st_d;
      ret_q     <= ret_d;
      rq_wr_q   <= rq_wr_d;
      rq_addr_q <= rq_addr_d;
      rq_data_q <= rq_data_d;
      sn_addr_q <= sn_addr_d;
      sn_src_q  <= sn_src_d;
    end
  end

  // R4: a memory request holds its command until the lower level takes it
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  // R10: a data reply holds until the fabric takes it
  p_reply_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid && bus_out_type == MSG_DATA && !bus_out_ready |=> bus_out_valid && $stable(bus_out_addr));
  // R10: a data reply is preceded by a completed write-back
  p_reply_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_out_valid && bus_out_type == MSG_DATA) |-> $past(mem_req_valid && mem_req_ready && mem_req_write));
  // R3: every outgoing message carries a line-aligned address
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> bus_out_addr[OFF_W-1:0] == '0);
  // R2: each response is a single-cycle pulse
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
  // R13: a local request accepted leaves no room for a second one next cycle
  p_one_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
endmodule

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_NONE = 2'b00, K_RD = 2'b01, K_INV = 2'b10, K_DATA = 2'b11;
  localparam logic [1:0] ME = 2'd1, PEER = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0;
  logic [31:0] cpu_req_addr = '0;
  logic [63:0] cpu_req_wdata = '0;
  logic cpu_rsp_valid;
  logic [63:0] cpu_rsp_data;
  logic bus_out_valid, bus_out_ready = 0;
  logic [1:0] bus_out_type, bus_out_src, bus_out_dest;
  logic [31:0] bus_out_addr;
  logic [63:0] bus_out_data;
  logic bus_in_valid = 0, bus_in_ready;
  logic [1:0] bus_in_type = '0, bus_in_src = '0, bus_in_dest = '0;
  logic [31:0] bus_in_addr = '0;
  logic [63:0] bus_in_data = '0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;

  int n_tests = 0, n_fail = 0;
  int bus_act = 0, mem_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_coh_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .bus_out_valid(bus_out_valid), .bus_out_ready(bus_out_ready), .bus_out_type(bus_out_type),
    .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data), .bus_out_src(bus_out_src),
    .bus_out_dest(bus_out_dest),
    .bus_in_valid(bus_in_valid), .bus_in_ready(bus_in_ready), .bus_in_type(bus_in_type),
    .bus_in_addr(bus_in_addr), .bus_in_data(bus_in_data), .bus_in_src(bus_in_src),
    .bus_in_dest(bus_in_dest),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always @(negedge clk) begin
    if (bus_out_valid) bus_act++;
    if (mem_req_valid) mem_act++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit wr, input logic [31:0] addr, input logic [63:0] data);
    int t = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = data;
    while (!cpu_req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic expect_rsp(input logic [63:0] data, input string req);
    int t = 0;
    while (!cpu_rsp_valid && t < 100) begin @(negedge clk); t++; end
    chk(cpu_rsp_valid && cpu_rsp_data == data, req, cpu_rsp_data, data);
    @(negedge clk);
  endtask

  task automatic expect_bus(input logic [1:0] kind, input logic [31:0] addr,
                            input logic [1:0] dest, input logic [63:0] data, input string req);
    int t = 0;
    while (!bus_out_valid && t < 100) begin @(negedge clk); t++; end
    chk(bus_out_valid && bus_out_type == kind, req, {62'd0, bus_out_type}, {62'd0, kind});
    chk(bus_out_addr == addr && bus_out_src == ME, req, {32'd0, bus_out_addr}, {32'd0, addr});
    if (kind == K_DATA)
      chk(bus_out_data == data && bus_out_dest == dest, req, bus_out_data, data);
    bus_out_ready = 1;
    @(negedge clk);
    bus_out_ready = 0;
  endtask

  task automatic expect_mem(input bit wr, input logic [31:0] addr, input logic [63:0] wdata,
                            input logic [63:0] rdata, input string req);
    int t = 0;
    while (!mem_req_valid && t < 100) begin @(negedge clk); t++; end
    chk(mem_req_valid && mem_req_write == wr && mem_req_addr == addr, req,
        {31'd0, mem_req_write, mem_req_addr}, {31'd0, wr, addr});
    if (wr) chk(mem_req_wdata == wdata, req, mem_req_wdata, wdata);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    if (!wr) begin
      mem_rsp_valid = 1; mem_rsp_data = rdata;
      @(negedge clk);
      mem_rsp_valid = 0;
    end
  endtask

  task automatic send_in(input logic [1:0] kind, input logic [31:0] addr, input logic [63:0] data,
                         input logic [1:0] src, input logic [1:0] dest);
    int t = 0;
    bus_in_valid = 1; bus_in_type = kind; bus_in_addr = addr; bus_in_data = data;
    bus_in_src = src; bus_in_dest = dest;
    while (!bus_in_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    bus_in_valid = 0;
  endtask

  task automatic expect_quiet(input int b0, input int m0, input string req);
    chk(bus_act == b0 && mem_act == m0, req, {32'(bus_act), 32'(mem_act)}, {32'(b0), 32'(m0)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cpu_req_ready && !bus_out_valid && !mem_req_valid, "R1", {61'd0, cpu_req_ready, bus_out_valid, mem_req_valid}, 64'h4);
  endtask

  task automatic t_read_miss_mem;
    cpu_op(0, 32'h1000_000C, '0);
    expect_bus(K_RD, 32'h1000_0008, 0, 0, "R3");
    send_in(K_NONE, 32'h1000_0008, 0, 2'd0, ME);
    expect_mem(0, 32'h1000_0008, 0, 64'h1111_2222_3333_4444, "R4");
    expect_rsp(64'h1111_2222_3333_4444, "R4");
  endtask

  task automatic t_read_hit;
    int b0 = bus_act, m0 = mem_act;
    cpu_op(0, 32'h1000_000D, '0);
    expect_rsp(64'h1111_2222_3333_4444, "R2");
    expect_quiet(b0, m0, "R2");
  endtask

  task automatic t_read_miss_peer;
    int m0;
    cpu_op(0, 32'h2000_0010, '0);
    expect_bus(K_RD, 32'h2000_0010, 0, 0, "R3");
    m0 = mem_act;
    send_in(K_DATA, 32'h2000_0010, 64'hAAAA_0000_BBBB_0002, PEER, ME);
    expect_rsp(64'hAAAA_0000_BBBB_0002, "R5");
    chk(mem_act == m0, "R5", 64'(mem_act), 64'(m0));
  endtask

  task automatic t_write_clean_then_snoop;
    int b0, m0;
    cpu_op(1, 32'h2000_0010, 64'hC0DE_0000_0000_0001);
    expect_bus(K_INV, 32'h2000_0010, 0, 0, "R8");
    expect_rsp(64'hC0DE_0000_0000_0001, "R8");
    send_in(K_RD, 32'h2000_0010, 0, PEER, 2'd0);
    expect_mem(1, 32'h2000_0010, 64'hC0DE_0000_0000_0001, 0, "R10");
    expect_bus(K_DATA, 32'h2000_0010, PEER, 64'hC0DE_0000_0000_0001, "R10");
    b0 = bus_act; m0 = mem_act;
    send_in(K_RD, 32'h2000_0010, 0, PEER, 2'd0);
    repeat (4) @(negedge clk);
    expect_quiet(b0, m0, "R11");
  endtask

  task automatic t_write_dirty;
    int b0, m0;
    cpu_op(1, 32'h2000_0010, 64'hC0DE_0000_0000_0002);
    expect_bus(K_INV, 32'h2000_0010, 0, 0, "R8");
    expect_rsp(64'hC0DE_0000_0000_0002, "R8");
    b0 = bus_act; m0 = mem_act;
    cpu_op(1, 32'h2000_0010, 64'hC0DE_0000_0000_0003);
    expect_rsp(64'hC0DE_0000_0000_0003, "R7");
    expect_quiet(b0, m0, "R7");
  endtask

  task automatic t_write_allocate;
    cpu_op(1, 32'h3000_001C, 64'hFEED_0000_0000_0004);
    expect_bus(K_RD, 32'h3000_0018, 0, 0, "R6");
    send_in(K_NONE, 32'h3000_0018, 0, 2'd0, ME);
    expect_mem(0, 32'h3000_0018, 0, 64'h3333_3333_3333_3333, "R6");
    expect_bus(K_INV, 32'h3000_0018, 0, 0, "R6");
    expect_rsp(64'hFEED_0000_0000_0004, "R6");
    send_in(K_RD, 32'h3000_0018, 0, PEER, 2'd0);
    expect_mem(1, 32'h3000_0018, 64'hFEED_0000_0000_0004, 0, "R6");
    expect_bus(K_DATA, 32'h3000_0018, PEER, 64'hFEED_0000_0000_0004, "R10");
  endtask

  task automatic t_victim;
    cpu_op(0, 32'h4000_0010, '0);
    expect_mem(1, 32'h2000_0010, 64'hC0DE_0000_0000_0003, 0, "R12");
    expect_bus(K_RD, 32'h4000_0010, 0, 0, "R12");
    send_in(K_NONE, 32'h4000_0010, 0, 2'd0, ME);
    expect_mem(0, 32'h4000_0010, 0, 64'h4444_4444_0000_0004, "R12");
    expect_rsp(64'h4444_4444_0000_0004, "R12");
  endtask

  task automatic t_snoop_inv;
    int b0, m0;
    send_in(K_INV, 32'h5000_0008, 0, PEER, 2'd0);
    b0 = bus_act; m0 = mem_act;
    cpu_op(0, 32'h1000_0008, '0);
    expect_rsp(64'h1111_2222_3333_4444, "R9");
    expect_quiet(b0, m0, "R9");
    send_in(K_INV, 32'h1000_0008, 0, PEER, 2'd0);
    cpu_op(0, 32'h1000_0008, '0);
    expect_bus(K_RD, 32'h1000_0008, 0, 0, "R9");
    send_in(K_DATA, 32'h1000_0008, 64'h5555_0000_5555_0005, PEER, ME);
    expect_rsp(64'h5555_0000_5555_0005, "R9");
  endtask

  task automatic t_priority;
    int b0, m0, t;
    @(negedge clk);
    b0 = bus_act; m0 = mem_act;
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 32'h4000_0010;
    bus_in_valid = 1; bus_in_type = K_RD; bus_in_addr = 32'h4000_0010; bus_in_src = PEER;
    #1;
    chk(!cpu_req_ready && bus_in_ready, "R13", {62'd0, cpu_req_ready, bus_in_ready}, 64'h1);
    @(negedge clk);
    bus_in_valid = 0;
    t = 0;
    while (!cpu_req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    cpu_req_valid = 0;
    expect_rsp(64'h4444_4444_0000_0004, "R11");
    expect_quiet(b0, m0, "R11");
    send_in(K_INV, 32'h4000_0010, 0, ME, 2'd0);
    b0 = bus_act; m0 = mem_act;
    cpu_op(0, 32'h4000_0010, '0);
    expect_rsp(64'h4444_4444_0000_0004, "R13");
    expect_quiet(b0, m0, "R13");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_miss_mem();
    t_read_hit();
    t_read_miss_peer();
    t_write_clean_then_snoop();
    t_write_dirty();
    t_write_allocate();
    t_victim();
    t_snoop_inv();
    t_priority();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule